// File: doc/BRIEF.md
# Synchronized Receive Slot Scheduler

This block keeps a duty-cycled receiver locked to a transmitter that sends one packet per fixed period. All timing is counted in strobes of a slow, low-power crystal (`tick_i`). After power-up the block waits a settling time. It then acquires: the reference oscillator and the receiver both stay on until a packet arrives or a timeout expires. Once a packet has been received, the block tracks. It powers the reference oscillator and then the receiver only in a short window around the expected frame start, and turns them off again when the packet is done or the window has passed.

Each packet received in tracking is compared with its predicted arrival time. The signed error is reported as lateness, and a fraction of it is added to a running period deviation. That deviation moves every later prediction. A missed slot widens the next window. A run of missed slots sends the block back to acquisition. If acquisition fails, the block sleeps for a pause before it tries again. The radio's demodulator supplies the frame-delimiter, packet-good and packet-timeout strobes. The radio itself and the host software are outside this block.

Top module: `rx_slot_sched`

## Requirements
- R1: While reset is asserted and during the settling time, `mode_o` is 0 (settling), both enables are low, and `period_dev_o` and `lateness_o` are 0. The settling time is `cfg_settle_i` ticks counted from reset release. On the tick that completes it, `mode_o` becomes 1 (acquiring) and both enables go high.
- R2: In acquisition both enables stay high. A `sfd_i` followed by `pkt_ok_i` records the delimiter time as the anchor and enters tracking: `mode_o` is 2, and both enables are low until the first slot opens.
- R3: In tracking, let E be `cfg_period_i` plus the period deviation, and let m be the current margin. The elapsed ticks since the anchor are compared against E. `xtal_en_o` rises on the tick where elapsed reaches E − m − `cfg_xtal_lead_i`. `rx_en_o` rises on the tick where elapsed reaches E − m.
- R4: If no delimiter has been seen by the tick where elapsed reaches E + m, both enables drop on that tick and the slot counts as missed. A `sfd_i` that arrives in the same cycle as that tick wins: the receiver stays on.
- R5: After a delimiter in a slot, both enables stay high until `pkt_ok_i` (a hit) or `pkt_tmo_i` (a miss). On a miss the anchor advances by E.
- R6: The margin is `cfg_margin_sync_i` for the first slot after acquisition. It is `cfg_margin_min_i` after a hit and four times `cfg_margin_min_i` after a miss.
- R7: When the number of consecutive misses reaches `cfg_miss_limit_i` (at least 1), the block returns to acquisition. The acquisition timeout is then `cfg_resync_per_i` × `cfg_period_i` ticks.
- R8: The first acquisition after settling times out after `cfg_init_tmo_i` ticks. On timeout, `mode_o` becomes 3 (paused) with both enables low for `cfg_pause_i` ticks. Acquisition then restarts with the resync timeout.
- R9: On each hit in tracking, `lateness_o` becomes delimiter elapsed − E, and `period_dev_o` increases by lateness arithmetically shifted right by `LPF_SHIFT`. Both values are two's complement in ticks and hold between hits.
- R10: A `pkt_tmo_i` during acquisition leaves the block in acquisition with both enables high.
- R11: Elapsed time is the tick counter minus the anchor, taken modulo 2^`TW` and read as a signed value. Slot timing therefore stays correct across counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per low-power crystal tick |
| sfd_i | input | 1 | Frame delimiter detected strobe |
| pkt_ok_i | input | 1 | Packet received correctly strobe |
| pkt_tmo_i | input | 1 | Packet receive timeout strobe |
| cfg_settle_i | input | AW | Settling time after reset, ticks |
| cfg_init_tmo_i | input | AW | First acquisition timeout, ticks |
| cfg_resync_per_i | input | CW | Resync acquisition timeout, in periods |
| cfg_pause_i | input | AW | Sleep after failed acquisition, ticks |
| cfg_period_i | input | TW | Nominal packet period, ticks |
| cfg_xtal_lead_i | input | MW | Oscillator startup before receiver on, ticks |
| cfg_margin_min_i | input | MW | Normal window margin, ticks |
| cfg_margin_sync_i | input | MW | Margin of first slot after acquisition |
| cfg_miss_limit_i | input | CW | Consecutive misses before resync |
| xtal_en_o | output | 1 | Reference oscillator enable |
| rx_en_o | output | 1 | Receiver enable |
| mode_o | output | 2 | 0 settling, 1 acquiring, 2 tracking, 3 paused |
| period_dev_o | output | TW | Filtered period deviation, signed ticks |
| lateness_o | output | TW | Lateness of last tracked packet, signed ticks |

## Verification
Two events can fall in the same cycle: a frame delimiter, and the tick that closes a slot window. The bench provokes this by raising `sfd_i` together with the tick that brings elapsed time to exactly E + m. It then expects the receiver to stay on, and after `pkt_ok_i` it expects a lateness of exactly +m. A similar overlap is a delimiter and the acquisition-expiry tick, where the delimiter also takes priority. The scoreboard judges every outcome against a model that tracks time as an unbounded integer. That model is independent of the design's modulo counter, so the comparison also covers counter wrap.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [1:0] {
    MODE_SETTLE = 2'd0,
    MODE_ACQ    = 2'd1,
    MODE_TRACK  = 2'd2,
    MODE_PAUSE  = 2'd3
  } rxs_mode_e;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_SETTLE,
    ST_ACQ,
    ST_ACQ_RX,
    ST_WAIT,
    ST_XTAL,
    ST_SLOT,
    ST_RECV,
    ST_PAUSE
  } rxs_state_e;

  typedef enum logic [1:0] {
    MG_SYNC,
    MG_MIN,
    MG_WIDE
  } rxs_msel_e;

endpackage

// File: rtl/rxs_tick_timer.sv
module rxs_tick_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  input  logic         tick_i,
  output logic         expire_o
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load_i)              cnt <= value_i;
    else if (tick_i && cnt != '0) cnt <= cnt - 1'b1;
  end

  // expiry coincides with the tick that uses up the count
  assign expire_o = tick_i && (cnt <= W'(1));

  // R8
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> cnt <= $past(cnt));

endmodule

// File: rtl/rxs_period_lpf.sv
module rxs_period_lpf #(
  parameter int TW    = 16,
  parameter int SW    = 19,
  parameter int SHIFT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_i,
  input  logic signed [SW-1:0] sfd_el_i,
  input  logic signed [SW-1:0] exp_i,
  output logic signed [TW-1:0] dev_o,
  output logic signed [TW-1:0] late_o
);

  logic signed [SW-1:0] err_full;
  logic signed [TW-1:0] err;

  assign err_full = sfd_el_i - exp_i;
  assign err      = TW'(err_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_o  <= '0;
      late_o <= '0;
    end else if (upd_i) begin
      late_o <= err;
      dev_o  <= dev_o + (err >>> SHIFT);
    end
  end

  // R9
  filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(dev_o) && $stable(late_o));

endmodule

// File: rtl/rxs_margin_sel.sv
module rxs_margin_sel
  import rxs_pkg::*;
#(
  parameter int MW   = 8,
  parameter int WSHL = 2
) (
  input  rxs_msel_e          sel_i,
  input  logic [MW-1:0]      m_sync_i,
  input  logic [MW-1:0]      m_min_i,
  output logic [MW+WSHL-1:0] m_o
);

  logic [MW+WSHL-1:0] wide;

  generate
    if (WSHL == 0) begin : g_flat
      assign wide = m_min_i;
    end else begin : g_scaled
      assign wide = {m_min_i, {WSHL{1'b0}}};
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      MG_SYNC: m_o = (MW+WSHL)'(m_sync_i);
      MG_WIDE: m_o = wide;
      default: m_o = (MW+WSHL)'(m_min_i);
    endcase
  end

endmodule

// File: rtl/rx_slot_sched.sv
module rx_slot_sched
  import rxs_pkg::*;
#(
  parameter int TW        = 16,
  parameter int MW        = 8,
  parameter int CW        = 8,
  parameter int AW        = 24,
  parameter int LPF_SHIFT = 2,
  parameter int WSHL      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          sfd_i,
  input  logic          pkt_ok_i,
  input  logic          pkt_tmo_i,
  input  logic [AW-1:0] cfg_settle_i,
  input  logic [AW-1:0] cfg_init_tmo_i,
  input  logic [CW-1:0] cfg_resync_per_i,
  input  logic [AW-1:0] cfg_pause_i,
  input  logic [TW-1:0] cfg_period_i,
  input  logic [MW-1:0] cfg_xtal_lead_i,
  input  logic [MW-1:0] cfg_margin_min_i,
  input  logic [MW-1:0] cfg_margin_sync_i,
  input  logic [CW-1:0] cfg_miss_limit_i,
  output logic          xtal_en_o,
  output logic          rx_en_o,
  output logic [1:0]    mode_o,
  output logic [TW-1:0] period_dev_o,
  output logic [TW-1:0] lateness_o
);

  localparam int MXW = MW + WSHL;
  localparam int SW  = ((TW > MXW) ? TW : MXW) + 2;
  localparam int PW  = CW + TW;

  rxs_state_e st;
  rxs_msel_e  msel;
  logic [TW-1:0] now, cur, anchor, sfd_ts;
  logic [CW-1:0] miss_cnt;
  logic [MXW-1:0] margin;
  logic signed [TW-1:0] dev, late;
  logic signed [SW-1:0] el, sfd_el, exp_t, open_x, open_rx, close_t;
  logic [PW-1:0] resync_prod;
  logic [AW-1:0] tmr_val;
  logic tmr_load, expire;
  logic ev_hit, ev_miss, ev_fall, ev_sync, ev_acq_exp, ev_settle_end, ev_pause_end;

  // modulo elapsed time, read as signed
  assign cur     = tick_i ? now + 1'b1 : now;
  assign el      = SW'($signed(cur - anchor));
  assign sfd_el  = SW'($signed(sfd_ts - anchor));
  assign exp_t   = $signed(SW'(cfg_period_i)) + SW'(dev);
  assign open_rx = exp_t - $signed(SW'(margin));
  assign open_x  = open_rx - $signed(SW'(cfg_xtal_lead_i));
  assign close_t = exp_t + $signed(SW'(margin));

  assign ev_settle_end = (st == ST_SETTLE) && expire;
  assign ev_acq_exp    = (st == ST_ACQ) && !sfd_i && expire;
  assign ev_pause_end  = (st == ST_PAUSE) && expire;
  assign ev_sync       = (st == ST_ACQ_RX) && pkt_ok_i;
  assign ev_hit        = (st == ST_RECV) && pkt_ok_i;
  assign ev_miss       = ((st == ST_SLOT) && !sfd_i && tick_i && (el >= close_t))
                       || ((st == ST_RECV) && !pkt_ok_i && pkt_tmo_i);
  assign ev_fall       = ev_miss && (({1'b0, miss_cnt} + 1'b1) >= {1'b0, cfg_miss_limit_i});

  assign resync_prod = PW'(cfg_resync_per_i) * PW'(cfg_period_i);
  assign tmr_load    = (st == ST_BOOT) || ev_settle_end || ev_acq_exp || ev_pause_end || ev_fall;

  always_comb begin
    if (st == ST_BOOT)   tmr_val = cfg_settle_i;
    else if (ev_settle_end) tmr_val = cfg_init_tmo_i;
    else if (ev_acq_exp) tmr_val = cfg_pause_i;
    else                 tmr_val = AW'(resync_prod);
  end

  rxs_tick_timer #(.W(AW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .value_i(tmr_val),
    .tick_i(tick_i), .expire_o(expire)
  );

  rxs_period_lpf #(.TW(TW), .SW(SW), .SHIFT(LPF_SHIFT)) u_lpf (
    .clk(clk), .rst_n(rst_n), .upd_i(ev_hit), .sfd_el_i(sfd_el),
    .exp_i(exp_t), .dev_o(dev), .late_o(late)
  );

  rxs_margin_sel #(.MW(MW), .WSHL(WSHL)) u_msel (
    .sel_i(msel), .m_sync_i(cfg_margin_sync_i), .m_min_i(cfg_margin_min_i), .m_o(margin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_BOOT;
      msel     <= MG_SYNC;
      now      <= '0;
      anchor   <= '0;
      sfd_ts   <= '0;
      miss_cnt <= '0;
    end else begin
      now <= cur;
      unique case (st)
        ST_BOOT:   st <= ST_SETTLE;
        ST_SETTLE: if (ev_settle_end) st <= ST_ACQ;
        ST_ACQ: begin
          if (sfd_i) begin
            sfd_ts <= cur;
            st     <= ST_ACQ_RX;
          end else if (ev_acq_exp) st <= ST_PAUSE;
        end
        ST_ACQ_RX: begin
          if (ev_sync) begin
            anchor   <= sfd_ts;
            msel     <= MG_SYNC;
            miss_cnt <= '0;
            st       <= ST_WAIT;
          end else if (pkt_tmo_i) st <= ST_ACQ;
        end
        ST_WAIT: if (tick_i && el >= open_x) st <= ST_XTAL;
        ST_XTAL: if (tick_i && el >= open_rx) st <= ST_SLOT;
        ST_SLOT: begin
          if (sfd_i) begin
            sfd_ts <= cur;
            st     <= ST_RECV;
          end
        end
        ST_RECV: begin
          if (ev_hit) begin
            anchor   <= sfd_ts;
            msel     <= MG_MIN;
            miss_cnt <= '0;
            st       <= ST_WAIT;
          end
        end
        ST_PAUSE: if (ev_pause_end) st <= ST_ACQ;
        default:  st <= ST_BOOT;
      endcase
      if (ev_miss) begin
        if (ev_fall) begin
          miss_cnt <= '0;
          st       <= ST_ACQ;
        end else begin
          miss_cnt <= miss_cnt + 1'b1;
          anchor   <= anchor + TW'(exp_t);
          msel     <= MG_WIDE;
          st       <= ST_WAIT;
        end
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_BOOT, ST_SETTLE: mode_o = MODE_SETTLE;
      ST_ACQ, ST_ACQ_RX:  mode_o = MODE_ACQ;
      ST_PAUSE:           mode_o = MODE_PAUSE;
      default:            mode_o = MODE_TRACK;
    endcase
  end

  assign xtal_en_o    = (st == ST_ACQ) || (st == ST_ACQ_RX) || (st == ST_XTAL)
                     || (st == ST_SLOT) || (st == ST_RECV);
  assign rx_en_o      = (st == ST_ACQ) || (st == ST_ACQ_RX) || (st == ST_SLOT) || (st == ST_RECV);
  assign period_dev_o = dev;
  assign lateness_o   = late;

  // R3
  xtal_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_en_o) && mode_o == MODE_TRACK |-> $past(xtal_en_o));

  // R4
  slot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_en_o) && mode_o == MODE_TRACK |-> !xtal_en_o);

  // R8
  pause_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == MODE_PAUSE && $past(mode_o) != MODE_PAUSE |-> $past(mode_o) == MODE_ACQ);

  // R7
  miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_miss_limit_i != '0 |-> miss_cnt < cfg_miss_limit_i);

  // R1
  settle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == MODE_SETTLE |-> period_dev_o == '0 && lateness_o == '0);

  // R2
  anchor_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(anchor) |-> st == ST_WAIT || st == ST_ACQ);

endmodule

// File: tb/sim_rx_slot_sched.sv
`timescale 1ns/1ps
module sim_rx_slot_sched;

  localparam int TW = 9, MW = 8, CW = 8, AW = 24, SH = 2;
  localparam int PER = 50, XL = 2, MMIN = 3, MSYNC = 8, NMISS = 2;
  localparam int SETTLE = 3, INIT = 20, RPER = 2, PAUSE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sfd = 1'b0, ok = 1'b0, tmo = 1'b0;
  logic xtal_en, rx_en;
  logic [1:0] mode;
  logic [TW-1:0] dev_o, late_o;

  always #2 clk = ~clk;

  rx_slot_sched #(.TW(TW), .MW(MW), .CW(CW), .AW(AW), .LPF_SHIFT(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sfd_i(sfd), .pkt_ok_i(ok), .pkt_tmo_i(tmo),
    .cfg_settle_i(AW'(SETTLE)), .cfg_init_tmo_i(AW'(INIT)), .cfg_resync_per_i(CW'(RPER)),
    .cfg_pause_i(AW'(PAUSE)), .cfg_period_i(TW'(PER)), .cfg_xtal_lead_i(MW'(XL)),
    .cfg_margin_min_i(MW'(MMIN)), .cfg_margin_sync_i(MW'(MSYNC)), .cfg_miss_limit_i(CW'(NMISS)),
    .xtal_en_o(xtal_en), .rx_en_o(rx_en), .mode_o(mode),
    .period_dev_o(dev_o), .lateness_o(late_o)
  );

  typedef struct {
    int    mode;
    bit    xe;
    bit    re;
    int    dev;
    int    late;
    string tag;
  } item_t;

  item_t q[$];
  item_t cur_item;
  int n_chk = 0, n_fail = 0;
  int now_t = 0, anchor = 0, m_dev = 0, m_late = 0, mg = MSYNC;
  bit done = 1'b0;

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur_item = q.pop_front();
      n_chk++;
      if (int'(mode) != cur_item.mode || xtal_en != cur_item.xe || rx_en != cur_item.re ||
          int'($signed(dev_o)) != cur_item.dev || int'($signed(late_o)) != cur_item.late) begin
        n_fail++;
        $display("FAIL %s: got mode=%0d xtal=%0b rx=%0b dev=%0d late=%0d, expected mode=%0d xtal=%0b rx=%0b dev=%0d late=%0d",
                 cur_item.tag, mode, xtal_en, rx_en, $signed(dev_o), $signed(late_o),
                 cur_item.mode, cur_item.xe, cur_item.re, cur_item.dev, cur_item.late);
      end
    end
  end

  task automatic expect_st(input int md, input bit x, input bit r, input string tag);
    q.push_back('{md, x, r, m_dev, m_late, tag});
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    now_t++;
  endtask

  task automatic tk_sfd();
    @(negedge clk); tick = 1'b1; sfd = 1'b1;
    @(negedge clk); tick = 1'b0; sfd = 1'b0;
    now_t++;
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) tk();
  endtask

  task automatic run_to(input int e);
    while (now_t - anchor < e) tk();
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) sfd = 1'b1; else if (which == 1) ok = 1'b1; else tmo = 1'b1;
    @(negedge clk);
    sfd = 1'b0; ok = 1'b0; tmo = 1'b0;
  endtask

  function automatic int expd();
    return PER + m_dev;
  endfunction

  // R3: opening sequence of a tracking slot
  task automatic slot_open(input string tag);
    run_to(expd() - mg - XL - 1);
    expect_st(2, 0, 0, tag);
    tk();
    expect_st(2, 1, 0, tag);
    run_to(expd() - mg - 1);
    expect_st(2, 1, 0, tag);
    tk();
    expect_st(2, 1, 1, tag);
  endtask

  // delimiter now (no tick) then good packet, model per R9
  task automatic track_hit(input string tag);
    int ts;
    pulse(0);
    ts = now_t;
    expect_st(2, 1, 1, tag);
    pulse(1);
    m_late = (ts - anchor) - expd();
    m_dev  = m_dev + (m_late >>> SH);
    anchor = ts;
    mg     = MMIN;
    expect_st(2, 0, 0, tag);
  endtask

  task automatic model_miss();
    anchor = anchor + expd();
    mg     = MMIN * 4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_st(0, 0, 0, "R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    adv(SETTLE - 1);
    expect_st(0, 0, 0, "R1 settling");
    tk();
    expect_st(1, 1, 1, "R1 acquire after settle");

    adv(INIT - 1);
    expect_st(1, 1, 1, "R8 before init timeout");
    tk();
    expect_st(3, 0, 0, "R8 pause");
    adv(PAUSE - 1);
    expect_st(3, 0, 0, "R8 pause holds");
    tk();
    expect_st(1, 1, 1, "R8 retry acquisition");

    adv(5);
    pulse(0);
    expect_st(1, 1, 1, "R2 delimiter in acquisition");
    pulse(2);
    expect_st(1, 1, 1, "R10 timeout stays acquiring");
    adv(3);
    pulse(0);
    anchor = now_t;
    pulse(1);
    mg = MSYNC;
    expect_st(2, 0, 0, "R2 enter tracking");

    // slot 1: resync margin, late packet
    slot_open("R6 sync margin");
    run_to(57);
    track_hit("R9 late +7");

    // slot 2: min margin, early packet, negative shift
    slot_open("R6 min margin");
    run_to(49);
    track_hit("R9 early -2");

    // slot 3: no delimiter, window closes
    slot_open("R3 open");
    run_to(expd() + mg - 1);
    expect_st(2, 1, 1, "R4 window still open");
    tk();
    expect_st(2, 0, 0, "R4 window closed");
    model_miss();

    // slot 4: wide margin, delimiter on the closing tick
    slot_open("R6 wide margin");
    run_to(expd() + mg - 1);
    expect_st(2, 1, 1, "R4 before close");
    tk_sfd();
    expect_st(2, 1, 1, "R4 delimiter wins close");
    begin
      int ts;
      ts = now_t;
      pulse(1);
      m_late = (ts - anchor) - expd();
      m_dev  = m_dev + (m_late >>> SH);
      anchor = ts;
      mg     = MMIN;
    end
    expect_st(2, 0, 0, "R9 lateness equals margin");

    // slot 5: delimiter then packet timeout
    slot_open("R3 open after hit");
    run_to(51);
    pulse(0);
    expect_st(2, 1, 1, "R5 receiving");
    pulse(2);
    expect_st(2, 0, 0, "R5 timeout is a miss");
    model_miss();

    // slot 6: second miss falls back
    slot_open("R6 wide after timeout");
    run_to(expd() + mg - 1);
    expect_st(2, 1, 1, "R7 last window open");
    tk();
    expect_st(1, 1, 1, "R7 fall back to acquisition");
    adv(RPER * PER - 1);
    expect_st(1, 1, 1, "R7 resync timeout not yet");
    tk();
    expect_st(3, 0, 0, "R7 resync timeout");
    adv(PAUSE);
    expect_st(1, 1, 1, "R8 acquisition after pause");

    pulse(0);
    anchor = now_t;
    pulse(1);
    mg = MSYNC;
    expect_st(2, 0, 0, "R2 tracking again");
    for (int k = 0; k < 7; k++) begin
      slot_open("R11 wrap slot");
      run_to(expd());
      track_hit("R11 on-time packet");
    end

    done = 1'b1;
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 60000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule